// File: doc/BRIEF.md
# UART Automatic Flow Controller

This block decides when a UART may start a character and when it asks its peer to pause. It sits between the receive FIFO, the transmitter and the modem-control pins. The receive FIFO fill level drives a local ready output, which can be either request-to-send or data-terminal-ready. A hysteresis band stops that output from toggling around the trigger point. The matching remote ready input, either clear-to-send or data-set-ready, passes through a synchronizer and then gates the start of each new transmit character. A character that is already shifting always finishes.

Software flow control runs alongside the pin handshake. Each received character is compared with a programmed Xoff code and a programmed Xon code. An Xoff match suspends transmission and latches a status flag. An Xon match resumes transmission. In Xon-any mode, any received character resumes it. Two sticky flags act as interrupt sources: one for a change of the automatic hold state, one for an Xoff match. A single clear strobe resets both flags.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset both flags read 0, no hold and no suspension is active, the modem outputs follow the inverted manual bits (pin = ~mcr bit), and tx_start_ok_o reads 1 while auto_cts_en_i is 0.
- R2: With auto_rts_en_i set, a rx_level_i at or above rx_trig_i drives the selected ready output high (deasserted) one clock edge later.
- R3: Once held, the selected ready output returns low only when rx_level_i + rx_hyst_i < rx_trig_i. Levels inside the band keep it high.
- R4: With pair_dtr_i = 0 the automatic hold drives rts_no. With pair_dtr_i = 1 it drives dtr_no. The unselected pin always equals the inverse of its manual bit.
- R5: With auto_rts_en_i clear, each ready pin equals the inverse of its manual bit whatever the FIFO level, and the hold state is cleared at the next edge.
- R6: rts_irq_o sets on any change of the hold state while rts_irq_en_i is 1, stays set until flag_clr_i, and never sets while rts_irq_en_i is 0.
- R7: With auto_cts_en_i set and the selected remote input high (deasserted), tx_start_ok_o drops. A pin change reaches tx_start_ok_o after exactly two clock edges. With auto_cts_en_i clear, the pin has no effect.
- R8: pair_dtr_i = 0 gates on cts_ni and pair_dtr_i = 1 gates on dsr_ni. The other remote input is ignored.
- R9: With enh_en_i and sw_flow_en_i both set, a received character equal to xoff_char_i suspends transmission (tx_start_ok_o = 0) and sets xoff_irq_o at the next edge. An Xoff match takes priority over the Xon and Xon-any rules.
- R10: A received character equal to xon_char_i clears the suspension.
- R11: With xon_any_i set, any received character clears the suspension. With it clear, a character that matches neither code leaves the suspension in place.
- R12: With enh_en_i clear, received characters have no effect and any suspension is cleared at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| auto_rts_en_i | input | 1 | Enable automatic local ready output |
| auto_cts_en_i | input | 1 | Enable remote ready gating of transmit |
| pair_dtr_i | input | 1 | 0: RTS/CTS pair, 1: DTR/DSR pair |
| rts_irq_en_i | input | 1 | Enable hold-change flag |
| enh_en_i | input | 1 | Enhanced-function enable |
| sw_flow_en_i | input | 1 | Enable Xon/Xoff matching |
| xon_any_i | input | 1 | Any received character resumes |
| mcr_rts_i | input | 1 | Manual RTS level (1 = asserted) |
| mcr_dtr_i | input | 1 | Manual DTR level (1 = asserted) |
| rx_level_i | input | 7 | Receive FIFO fill level |
| rx_trig_i | input | 7 | Hold trigger level |
| rx_hyst_i | input | 7 | Release hysteresis |
| rx_valid_i | input | 1 | Received character strobe |
| rx_char_i | input | 8 | Received character |
| xoff_char_i | input | 8 | Xoff code |
| xon_char_i | input | 8 | Xon code |
| cts_ni | input | 1 | Remote clear-to-send, active low |
| dsr_ni | input | 1 | Remote data-set-ready, active low |
| flag_clr_i | input | 1 | Clear both flags |
| rts_no | output | 1 | Request-to-send, active low |
| dtr_no | output | 1 | Data-terminal-ready, active low |
| tx_start_ok_o | output | 1 | Transmitter may start a new character |
| rts_irq_o | output | 1 | Hold-state change flag |
| xoff_irq_o | output | 1 | Xoff match flag |

## Verification
The level walk crosses the trigger and then moves down through the hysteresis band, with one level exactly at trigger minus hysteresis. A comparator off by one there would either release too early or stay held one step too long. The remote input is sampled after one edge and again after two. A synchronizer with too few or too many stages would show the wrong value at one of those points. The Xon/Xoff tests send a non-matching character with Xon-any off and then with it on, and they turn the enhanced enable off while a suspension is active. Logic that ignored the mode bit, or left a stale suspension behind, would leave tx_start_ok_o wrong.

// File: rtl/flow_pkg.sv
package flow_pkg;
  typedef enum logic {
    PAIR_RTS_CTS = 1'b0,
    PAIR_DTR_DSR = 1'b1
  } pair_sel_e;
endpackage

// File: rtl/flow_sync.sv
module flow_sync #(
  parameter int   WIDTH   = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= {WIDTH{RST_VAL}};
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= {WIDTH{RST_VAL}};
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/flow_rts_ctrl.sv
module flow_rts_ctrl #(
  parameter int LEVEL_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [LEVEL_W-1:0] level_i,
  input  logic [LEVEL_W-1:0] trig_i,
  input  logic [LEVEL_W-1:0] hyst_i,
  output logic               hold_o,
  output logic               chg_o
);
  localparam int SUM_W = LEVEL_W + 1;

  logic [SUM_W-1:0] rel_sum;
  logic             hit, rel, hold_d, hold_q;

  // one extra bit so level + hyst cannot wrap
  assign rel_sum = {1'b0, level_i} + {1'b0, hyst_i};
  assign hit     = level_i >= trig_i;
  assign rel     = rel_sum < {1'b0, trig_i};

  always_comb begin
    hold_d = hold_q;
    if (!en_i)    hold_d = 1'b0;
    else if (hit) hold_d = 1'b1;
    else if (rel) hold_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= hold_d;
  end

  assign hold_o = hold_q;
  assign chg_o  = hold_d ^ hold_q;
endmodule

// File: rtl/flow_swfc.sv
module flow_swfc #(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              xon_any_i,
  input  logic              valid_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic [CHAR_W-1:0] xoff_char_i,
  input  logic [CHAR_W-1:0] xon_char_i,
  output logic              susp_o,
  output logic              xoff_hit_o
);
  logic susp_d, susp_q, is_xoff, is_xon;

  assign is_xoff    = en_i && valid_i && (char_i == xoff_char_i);
  assign is_xon     = en_i && valid_i && (char_i == xon_char_i);
  assign xoff_hit_o = is_xoff;

  always_comb begin
    susp_d = susp_q;
    if (!en_i)                            susp_d = 1'b0;
    else if (is_xoff)                     susp_d = 1'b1;
    else if (is_xon)                      susp_d = 1'b0;
    else if (valid_i && xon_any_i)        susp_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) susp_q <= 1'b0;
    else         susp_q <= susp_d;
  end

  assign susp_o = susp_q;
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import flow_pkg::*;
#(
  parameter int LEVEL_W     = 7,
  parameter int CHAR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               auto_rts_en_i,
  input  logic               auto_cts_en_i,
  input  logic               pair_dtr_i,
  input  logic               rts_irq_en_i,
  input  logic               enh_en_i,
  input  logic               sw_flow_en_i,
  input  logic               xon_any_i,
  input  logic               mcr_rts_i,
  input  logic               mcr_dtr_i,
  input  logic [LEVEL_W-1:0] rx_level_i,
  input  logic [LEVEL_W-1:0] rx_trig_i,
  input  logic [LEVEL_W-1:0] rx_hyst_i,
  input  logic               rx_valid_i,
  input  logic [CHAR_W-1:0]  rx_char_i,
  input  logic [CHAR_W-1:0]  xoff_char_i,
  input  logic [CHAR_W-1:0]  xon_char_i,
  input  logic               cts_ni,
  input  logic               dsr_ni,
  input  logic               flag_clr_i,
  output logic               rts_no,
  output logic               dtr_no,
  output logic               tx_start_ok_o,
  output logic               rts_irq_o,
  output logic               xoff_irq_o
);
  localparam int NUM_MODEM_IN = 2;

  pair_sel_e                pair;
  logic [NUM_MODEM_IN-1:0]  modem_sync;
  logic                     hold_q, hold_chg, susp_q, xoff_hit;
  logic                     remote_off, hw_block, sw_en;
  logic                     rts_irq_q, xoff_irq_q;

  assign pair  = pair_sel_e'(pair_dtr_i);
  assign sw_en = enh_en_i && sw_flow_en_i;

  flow_sync #(
    .WIDTH   (NUM_MODEM_IN),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({dsr_ni, cts_ni}),
    .q_o    (modem_sync)
  );

  flow_rts_ctrl #(.LEVEL_W(LEVEL_W)) u_rts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (auto_rts_en_i),
    .level_i (rx_level_i),
    .trig_i  (rx_trig_i),
    .hyst_i  (rx_hyst_i),
    .hold_o  (hold_q),
    .chg_o   (hold_chg)
  );

  flow_swfc #(.CHAR_W(CHAR_W)) u_swfc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (sw_en),
    .xon_any_i   (xon_any_i),
    .valid_i     (rx_valid_i),
    .char_i      (rx_char_i),
    .xoff_char_i (xoff_char_i),
    .xon_char_i  (xon_char_i),
    .susp_o      (susp_q),
    .xoff_hit_o  (xoff_hit)
  );

  // remote inputs are active low: a synced 1 means the peer is not ready
  assign remote_off = (pair == PAIR_DTR_DSR) ? modem_sync[1] : modem_sync[0];
  assign hw_block   = auto_cts_en_i && remote_off;

  // in-flight character is not affected; only new starts are gated
  assign tx_start_ok_o = !hw_block && !susp_q;

  assign rts_no = (auto_rts_en_i && pair == PAIR_RTS_CTS) ? hold_q : !mcr_rts_i;
  assign dtr_no = (auto_rts_en_i && pair == PAIR_DTR_DSR) ? hold_q : !mcr_dtr_i;

  // set wins over clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rts_irq_q  <= 1'b0;
      xoff_irq_q <= 1'b0;
    end else begin
      if (hold_chg && rts_irq_en_i) rts_irq_q <= 1'b1;
      else if (flag_clr_i)          rts_irq_q <= 1'b0;
      if (xoff_hit)                 xoff_irq_q <= 1'b1;
      else if (flag_clr_i)          xoff_irq_q <= 1'b0;
    end
  end

  assign rts_irq_o  = rts_irq_q;
  assign xoff_irq_o = xoff_irq_q;
endmodule

// File: rtl/flow_ctrl_chk.sv
module flow_ctrl_chk #(
  parameter int LEVEL_W = 7,
  parameter int CHAR_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               auto_rts_en_i,
  input logic               enh_en_i,
  input logic               sw_flow_en_i,
  input logic               rts_irq_en_i,
  input logic [LEVEL_W-1:0] rx_level_i,
  input logic [LEVEL_W-1:0] rx_trig_i,
  input logic [LEVEL_W-1:0] rx_hyst_i,
  input logic               rx_valid_i,
  input logic [CHAR_W-1:0]  rx_char_i,
  input logic [CHAR_W-1:0]  xoff_char_i,
  input logic               hold_q,
  input logic               susp_q,
  input logic               tx_start_ok_o,
  input logic               rts_irq_o,
  input logic               xoff_irq_o
);
  logic [LEVEL_W:0] band_sum;
  assign band_sum = {1'b0, rx_level_i} + {1'b0, rx_hyst_i};

  // R2
  hold_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_rts_en_i && rx_level_i >= rx_trig_i |=> hold_q);

  // R3
  hold_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_q) |-> $past(!auto_rts_en_i || band_sum < {1'b0, rx_trig_i}));

  // R5
  hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_rts_en_i |=> !hold_q);

  // R6
  rts_irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rts_irq_o) |-> $past(rts_irq_en_i));

  // R9
  xoff_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enh_en_i && sw_flow_en_i && rx_valid_i && rx_char_i == xoff_char_i
    |=> xoff_irq_o && !tx_start_ok_o);

  // R12
  enh_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enh_en_i |=> !susp_q);

  // R9
  susp_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_q |-> !tx_start_ok_o);
endmodule

bind uart_flow_ctrl flow_ctrl_chk #(.LEVEL_W(LEVEL_W), .CHAR_W(CHAR_W)) u_flow_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .auto_rts_en_i (auto_rts_en_i),
  .enh_en_i      (enh_en_i),
  .sw_flow_en_i  (sw_flow_en_i),
  .rts_irq_en_i  (rts_irq_en_i),
  .rx_level_i    (rx_level_i),
  .rx_trig_i     (rx_trig_i),
  .rx_hyst_i     (rx_hyst_i),
  .rx_valid_i    (rx_valid_i),
  .rx_char_i     (rx_char_i),
  .xoff_char_i   (xoff_char_i),
  .hold_q        (hold_q),
  .susp_q        (susp_q),
  .tx_start_ok_o (tx_start_ok_o),
  .rts_irq_o     (rts_irq_o),
  .xoff_irq_o    (xoff_irq_o)
);

// File: tb/uart_flow_ctrl_bench.sv
`timescale 1ns/1ps
module uart_flow_ctrl_bench;
  localparam int LEVEL_W = 7;
  localparam int CHAR_W  = 8;

  typedef struct packed {
    logic [LEVEL_W-1:0] lvl;
    logic               exp_pin;
  } lvl_vec_t;

  // trig 32, hyst 8: hold at >=32, release once level+8 < 32
  localparam int NVEC = 10;
  localparam lvl_vec_t VECS [NVEC] = '{
    '{7'd10, 1'b0}, '{7'd31, 1'b0}, '{7'd32, 1'b1}, '{7'd40, 1'b1},
    '{7'd30, 1'b1}, '{7'd24, 1'b1}, '{7'd23, 1'b0}, '{7'd31, 1'b0},
    '{7'd32, 1'b1}, '{7'd0,  1'b0}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic auto_rts_en = 0, auto_cts_en = 0, pair_dtr = 0, rts_irq_en = 0;
  logic enh_en = 0, sw_flow_en = 0, xon_any = 0, mcr_rts = 1, mcr_dtr = 1;
  logic [LEVEL_W-1:0] rx_level = '0, rx_trig = 7'd32, rx_hyst = 7'd8;
  logic rx_valid = 0;
  logic [CHAR_W-1:0] rx_char = '0;
  logic [CHAR_W-1:0] xoff_char = 8'h13, xon_char = 8'h11;
  logic cts_n = 0, dsr_n = 0, flag_clr = 0;
  logic rts_n, dtr_n, tx_ok, rts_irq, xoff_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_flow_ctrl u_uart_flow_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .auto_rts_en_i(auto_rts_en), .auto_cts_en_i(auto_cts_en),
    .pair_dtr_i(pair_dtr), .rts_irq_en_i(rts_irq_en),
    .enh_en_i(enh_en), .sw_flow_en_i(sw_flow_en), .xon_any_i(xon_any),
    .mcr_rts_i(mcr_rts), .mcr_dtr_i(mcr_dtr),
    .rx_level_i(rx_level), .rx_trig_i(rx_trig), .rx_hyst_i(rx_hyst),
    .rx_valid_i(rx_valid), .rx_char_i(rx_char),
    .xoff_char_i(xoff_char), .xon_char_i(xon_char),
    .cts_ni(cts_n), .dsr_ni(dsr_n), .flag_clr_i(flag_clr),
    .rts_no(rts_n), .dtr_no(dtr_n), .tx_start_ok_o(tx_ok),
    .rts_irq_o(rts_irq), .xoff_irq_o(xoff_irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // advance one edge, land on the next falling edge
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [CHAR_W-1:0] c);
    rx_char = c; rx_valid = 1;
    step();
    rx_valid = 0;
  endtask

  task automatic clr_flags();
    flag_clr = 1; step(); flag_clr = 0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(2);
    // R1 reset state
    chk("R1 rts_no", rts_n, 1'b0);
    chk("R1 dtr_no", dtr_n, 1'b0);
    chk("R1 tx_ok", tx_ok, 1'b1);
    chk("R1 rts_irq", rts_irq, 1'b0);
    chk("R1 xoff_irq", xoff_irq, 1'b0);
    rst_ni = 1;
    step(3);

    // R2 / R3 level walk on the RTS pin
    auto_rts_en = 1; rts_irq_en = 1;
    for (int v = 0; v < NVEC; v++) begin
      rx_level = VECS[v].lvl;
      step();
      chk($sformatf("R2/R3 level %0d rts_no", VECS[v].lvl), rts_n, VECS[v].exp_pin);
      chk("R4 dtr_no manual", dtr_n, 1'b0);
    end

    // R6 flag sets when enabled, clears, stays clear when disabled
    chk("R6 rts_irq set", rts_irq, 1'b1);
    clr_flags();
    chk("R6 rts_irq cleared", rts_irq, 1'b0);
    rts_irq_en = 0;
    rx_level = 7'd40; step();
    chk("R6 hold while disabled", rts_n, 1'b1);
    chk("R6 no flag when disabled", rts_irq, 1'b0);
    rx_level = 7'd0; step();

    // R4 DTR pair
    pair_dtr = 1; mcr_rts = 0;
    rx_level = 7'd40; step();
    chk("R4 dtr_no held", dtr_n, 1'b1);
    chk("R4 rts_no manual", rts_n, 1'b1);

    // R5 auto off: manual bit rules even at a high level
    auto_rts_en = 0; mcr_dtr = 1;
    step();
    chk("R5 dtr_no manual", dtr_n, 1'b0);
    mcr_dtr = 0; step();
    chk("R5 dtr_no manual low", dtr_n, 1'b1);
    auto_rts_en = 1; rx_level = 7'd24; step();
    chk("R5 hold cleared while off", dtr_n, 1'b0);
    auto_rts_en = 0; rx_level = 7'd0; mcr_dtr = 1;

    // R7 CTS gating and latency
    pair_dtr = 0; auto_cts_en = 1;
    cts_n = 1; step();
    chk("R7 one edge still ok", tx_ok, 1'b1);
    step();
    chk("R7 two edges blocked", tx_ok, 1'b0);
    cts_n = 0; step(2);
    chk("R7 resumed", tx_ok, 1'b1);
    cts_n = 1; auto_cts_en = 0; step(3);
    chk("R7 ignored when off", tx_ok, 1'b1);

    // R8 DSR selection
    auto_cts_en = 1; pair_dtr = 1; cts_n = 0; dsr_n = 1; step(2);
    chk("R8 dsr blocks", tx_ok, 1'b0);
    cts_n = 1; dsr_n = 0; step(2);
    chk("R8 cts ignored", tx_ok, 1'b1);
    auto_cts_en = 0; cts_n = 0; pair_dtr = 0; step(2);

    // R9 / R10 / R11 software flow control
    enh_en = 1; sw_flow_en = 1;
    send(xoff_char);
    chk("R9 suspended", tx_ok, 1'b0);
    chk("R9 flag", xoff_irq, 1'b1);
    send(8'h41);
    chk("R11 other char no resume", tx_ok, 1'b0);
    send(xon_char);
    chk("R10 xon resumes", tx_ok, 1'b1);
    clr_flags();
    chk("R9 flag cleared", xoff_irq, 1'b0);
    xon_any = 1;
    send(xoff_char);
    chk("R9 xoff wins over any", tx_ok, 1'b0);
    send(8'h41);
    chk("R11 any char resumes", tx_ok, 1'b1);
    xon_any = 0;
    clr_flags();

    // R12 enhanced disable
    enh_en = 0;
    send(xoff_char);
    chk("R12 char ignored", tx_ok, 1'b1);
    chk("R12 no flag", xoff_irq, 1'b0);
    enh_en = 1;
    send(xoff_char);
    chk("R12 suspended before off", tx_ok, 1'b0);
    enh_en = 0; step();
    chk("R12 suspension cleared", tx_ok, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule